// File: doc/BRIEF.md
# Stack Pointer and Frame Sequencer

This block owns the stack pointer and the frame (base) pointer of a descending stack kept in byte-addressed memory made of 8-byte words. On a command it issues the memory reads and writes that a push, a pop, a subroutine return, a frame setup or a frame teardown needs. Only one word moves per clock cycle. The frame commands are ordered multi-step sequences that run in hardware without outside help.

A host drives `cmd_valid` with an operation code, an operand and a local-frame size in bytes. The block raises `busy` on the cycle after it takes a command. It walks through one named state per step and ends in a single-cycle `done` strobe, which carries `fault` when an access found a misaligned stack pointer. The memory port is a simple one: the block drives address, write data and write enable, and the read data returns combinationally in the same cycle. Popped words appear on `pop_data`, and return addresses appear on `ret_target`.

States:
- `ST_IDLE`: waits for a command.
- `ST_PUSH`, `ST_POP`, `ST_RET`: each performs one access.
- `ST_ENT_SAVE` → `ST_ENT_LINK` → `ST_ENT_ALLOC`: frame setup. The old frame pointer is saved, the frame pointer is linked to the stack pointer, and the local space is reserved.
- `ST_LV_UNLINK` → `ST_LV_RESTORE` → `ST_LV_RET`: frame teardown. The stack pointer is dropped back to the frame pointer, the old frame pointer is restored, and the return address is popped.
- `ST_FINISH`: drives `done` and always returns to `ST_IDLE`.

An access state that sees a misaligned stack pointer jumps straight to `ST_FINISH`.

Top module: `stack_frame_unit`

## Requirements
- R1: After reset `stack_ptr` and `frame_ptr` equal their reset parameters (0x200 by default), `pop_data` and `ret_target` are zero, and `busy`, `done`, `fault` and `mem_we` are low.
- R2: Push (`cmd_op` = 3'd1) lowers `stack_ptr` by 8 and writes `cmd_data` at that lowered address. The block issues exactly one write, at old `stack_ptr` − 8.
- R3: Pop (`cmd_op` = 3'd2) places the word at `stack_ptr` on `pop_data` and raises `stack_ptr` by 8. It performs no write.
- R4: Return (`cmd_op` = 3'd3) places the word at `stack_ptr` on `ret_target` and raises `stack_ptr` by 8.
- R5: Frame setup (`cmd_op` = 3'd4) does three things in order. It stores the old `frame_ptr` at `stack_ptr` − 8. It sets `frame_ptr` to that address. It then lowers `stack_ptr` by a further `frame_size` bytes.
- R6: Frame teardown (`cmd_op` = 3'd5) does three things in order. It copies `frame_ptr` into `stack_ptr`. It reloads `frame_ptr` from the word at that address. It places the next word up on `ret_target`. `stack_ptr` finishes 16 above the old `frame_ptr`.
- R7: A command is taken only when `cmd_valid` is high while `busy` is low. `busy` stays high from the next cycle through the `done` cycle, and `done` lasts one cycle. `done` is seen 2 cycles after the taking edge for push, pop and return, and 4 cycles after it for frame setup and teardown. Commands offered while `busy` is high are ignored.
- R8: When an access step finds the low 3 bits of `stack_ptr` non-zero, the command ends with `fault` high during `done`. That step writes nothing and changes no pointer or result. Teardown keeps the pointer copy it already made and reports after 3 cycles; every other command reports after 2.
- R9: Operation codes 3'd0, 3'd6 and 3'd7 are ignored. `busy` and `done` stay low, and both pointers keep their values.
- R10: Each successful push or frame setup writes memory in exactly one cycle. Pop, return, teardown and faulting commands never assert `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | Operation code (1 push, 2 pop, 3 return, 4 frame setup, 5 frame teardown) |
| cmd_data | input | DATA_W | Value stored by push |
| frame_size | input | FRAME_W | Local space in bytes reserved by frame setup |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Misaligned stack pointer, valid with done |
| pop_data | output | DATA_W | Last word removed by pop |
| ret_target | output | DATA_W | Last return address removed |
| stack_ptr | output | DATA_W | Current stack pointer |
| frame_ptr | output | DATA_W | Current frame pointer |
| mem_addr | output | DATA_W | Byte address of the access |
| mem_wdata | output | DATA_W | Word to store |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | DATA_W | Word read at mem_addr, same cycle |

## Verification
A wrong state in the sequencer shows up at the ports within the command that caused it. A skipped or repeated step leaves `stack_ptr` or `frame_ptr` off by 8 or by the frame size when `done` arrives. It also shifts `done` away from its fixed cycle, or adds or drops a write strobe. A wrong address or data source corrupts a stored word, which appears either in the memory compare after that command or in `pop_data` or `ret_target` on a later pop, return or teardown. Nested frames driven by random traffic make a stale frame pointer surface at the matching teardown.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_PUSH  = 3'd1;
    localparam logic [OP_W-1:0] OP_POP   = 3'd2;
    localparam logic [OP_W-1:0] OP_RET   = 3'd3;
    localparam logic [OP_W-1:0] OP_ENTER = 3'd4;
    localparam logic [OP_W-1:0] OP_LEAVE = 3'd5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_RET,
        ST_ENT_SAVE,
        ST_ENT_LINK,
        ST_ENT_ALLOC,
        ST_LV_UNLINK,
        ST_LV_RESTORE,
        ST_LV_RET,
        ST_FINISH
    } stk_state_e;

    typedef enum logic [2:0] {
        SP_HOLD,
        SP_DOWN,
        SP_UP,
        SP_ALLOC,
        SP_FROM_BP
    } sp_sel_e;

    typedef enum logic [1:0] {
        BP_HOLD,
        BP_FROM_SP,
        BP_FROM_MEM
    } bp_sel_e;

    typedef enum logic [1:0] {
        CAP_NONE,
        CAP_POP,
        CAP_RET
    } cap_sel_e;

    typedef enum logic {
        WSRC_OPERAND,
        WSRC_FRAME
    } wsrc_e;

    typedef struct packed {
        sp_sel_e  sp_sel;
        bp_sel_e  bp_sel;
        cap_sel_e cap_sel;
        logic     mem_we;
        logic     addr_below;
        wsrc_e    wsrc;
    } stk_ctl_t;

    localparam stk_ctl_t CTL_REST = '{
        sp_sel:     SP_HOLD,
        bp_sel:     BP_HOLD,
        cap_sel:    CAP_NONE,
        mem_we:     1'b0,
        addr_below: 1'b0,
        wsrc:       WSRC_OPERAND
    };

endpackage

// File: rtl/stk_fsm.sv
module stk_fsm
    import stk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            misaligned,
    output stk_ctl_t        ctl,
    output logic            accept,
    output logic            busy,
    output logic            done,
    output logic            fault
);

    stk_state_e state_q;
    stk_state_e state_d;
    logic       fault_q;
    logic       access_step;

    // States that touch memory and therefore check alignment
    always_comb begin
        unique case (state_q)
            ST_PUSH, ST_POP, ST_RET,
            ST_ENT_SAVE, ST_LV_RESTORE, ST_LV_RET: access_step = 1'b1;
            default:                               access_step = 1'b0;
        endcase
    end

    // State register and fault flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (access_step) begin
                fault_q <= misaligned;
            end else if (state_q == ST_FINISH) begin
                fault_q <= 1'b0;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_PUSH:  state_d = ST_PUSH;
                        OP_POP:   state_d = ST_POP;
                        OP_RET:   state_d = ST_RET;
                        OP_ENTER: state_d = ST_ENT_SAVE;
                        OP_LEAVE: state_d = ST_LV_UNLINK;
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PUSH, ST_POP, ST_RET: state_d = ST_FINISH;
            ST_ENT_SAVE:   state_d = misaligned ? ST_FINISH : ST_ENT_LINK;
            ST_ENT_LINK:   state_d = ST_ENT_ALLOC;
            ST_ENT_ALLOC:  state_d = ST_FINISH;
            ST_LV_UNLINK:  state_d = ST_LV_RESTORE;
            ST_LV_RESTORE: state_d = misaligned ? ST_FINISH : ST_LV_RET;
            ST_LV_RET:     state_d = ST_FINISH;
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Per-state controls
    always_comb begin
        ctl = CTL_REST;
        unique case (state_q)
            ST_PUSH: begin
                if (!misaligned) begin
                    ctl.sp_sel     = SP_DOWN;
                    ctl.mem_we     = 1'b1;
                    ctl.addr_below = 1'b1;
                    ctl.wsrc       = WSRC_OPERAND;
                end
            end
            ST_POP: begin
                if (!misaligned) begin
                    ctl.sp_sel  = SP_UP;
                    ctl.cap_sel = CAP_POP;
                end
            end
            ST_RET: begin
                if (!misaligned) begin
                    ctl.sp_sel  = SP_UP;
                    ctl.cap_sel = CAP_RET;
                end
            end
            ST_ENT_SAVE: begin
                if (!misaligned) begin
                    ctl.sp_sel     = SP_DOWN;
                    ctl.mem_we     = 1'b1;
                    ctl.addr_below = 1'b1;
                    ctl.wsrc       = WSRC_FRAME;
                end
            end
            ST_ENT_LINK:  ctl.bp_sel = BP_FROM_SP;
            ST_ENT_ALLOC: ctl.sp_sel = SP_ALLOC;
            ST_LV_UNLINK: ctl.sp_sel = SP_FROM_BP;
            ST_LV_RESTORE: begin
                if (!misaligned) begin
                    ctl.sp_sel = SP_UP;
                    ctl.bp_sel = BP_FROM_MEM;
                end
            end
            ST_LV_RET: begin
                if (!misaligned) begin
                    ctl.sp_sel  = SP_UP;
                    ctl.cap_sel = CAP_RET;
                end
            end
            default: ;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && cmd_valid;
    assign busy   = (state_q != ST_IDLE);
    assign done   = (state_q == ST_FINISH);
    assign fault  = fault_q;

endmodule

// File: rtl/stk_ptrs.sv
module stk_ptrs
    import stk_pkg::*;
#(
    parameter int                DATA_W     = 64,
    parameter int                FRAME_W    = 16,
    parameter int                WORD_BYTES = 8,
    parameter logic [DATA_W-1:0] SP_INIT    = DATA_W'(512),
    parameter logic [DATA_W-1:0] BP_INIT    = DATA_W'(512)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [DATA_W-1:0]  cmd_data,
    input  logic [FRAME_W-1:0] frame_size,
    input  stk_ctl_t           ctl,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  sp,
    output logic [DATA_W-1:0]  bp,
    output logic [DATA_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               misaligned
);

    localparam int                ALIGN_BITS = $clog2(WORD_BYTES);
    localparam logic [DATA_W-1:0] STEP       = DATA_W'(WORD_BYTES);

    logic [DATA_W-1:0]  sp_q;
    logic [DATA_W-1:0]  bp_q;
    logic [DATA_W-1:0]  operand_q;
    logic [FRAME_W-1:0] frame_q;
    logic [DATA_W-1:0]  sp_below;

    assign sp_below = sp_q - STEP;

    // Command operands held for the steps that follow acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            operand_q <= '0;
            frame_q   <= '0;
        end else if (accept) begin
            operand_q <= cmd_data;
            frame_q   <= frame_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_INIT;
        end else begin
            unique case (ctl.sp_sel)
                SP_DOWN:    sp_q <= sp_below;
                SP_UP:      sp_q <= sp_q + STEP;
                SP_ALLOC:   sp_q <= sp_q - DATA_W'(frame_q);
                SP_FROM_BP: sp_q <= bp_q;
                default:    sp_q <= sp_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_q <= BP_INIT;
        end else begin
            unique case (ctl.bp_sel)
                BP_FROM_SP:  bp_q <= sp_q;
                BP_FROM_MEM: bp_q <= mem_rdata;
                default:     bp_q <= bp_q;
            endcase
        end
    end

    generate
        if (ALIGN_BITS == 0) begin : g_byte_words
            assign misaligned = 1'b0;
        end else begin : g_wide_words
            assign misaligned = |sp_q[ALIGN_BITS-1:0];
        end
    endgenerate

    assign mem_addr  = ctl.addr_below ? sp_below : sp_q;
    assign mem_wdata = (ctl.wsrc == WSRC_FRAME) ? bp_q : operand_q;
    assign sp        = sp_q;
    assign bp        = bp_q;

endmodule

// File: rtl/stk_capture.sv
module stk_capture
    import stk_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cap_sel_e          cap_sel,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] pop_data,
    output logic [DATA_W-1:0] ret_target
);

    logic [DATA_W-1:0] pop_q;
    logic [DATA_W-1:0] ret_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_q <= '0;
            ret_q <= '0;
        end else begin
            unique case (cap_sel)
                CAP_POP: pop_q <= mem_rdata;
                CAP_RET: ret_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    assign pop_data   = pop_q;
    assign ret_target = ret_q;

endmodule

// File: rtl/stack_frame_unit.sv
module stack_frame_unit
    import stk_pkg::*;
#(
    parameter int                DATA_W     = 64,
    parameter int                FRAME_W    = 16,
    parameter int                WORD_BYTES = 8,
    parameter logic [DATA_W-1:0] SP_INIT    = DATA_W'(512),
    parameter logic [DATA_W-1:0] BP_INIT    = DATA_W'(512)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [DATA_W-1:0]  cmd_data,
    input  logic [FRAME_W-1:0] frame_size,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [DATA_W-1:0]  pop_data,
    output logic [DATA_W-1:0]  ret_target,
    output logic [DATA_W-1:0]  stack_ptr,
    output logic [DATA_W-1:0]  frame_ptr,
    output logic [DATA_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we,
    input  logic [DATA_W-1:0]  mem_rdata
);

    stk_ctl_t ctl;
    logic     accept;
    logic     misaligned;

    stk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .misaligned (misaligned),
        .ctl        (ctl),
        .accept     (accept),
        .busy       (busy),
        .done       (done),
        .fault      (fault)
    );

    stk_ptrs #(
        .DATA_W     (DATA_W),
        .FRAME_W    (FRAME_W),
        .WORD_BYTES (WORD_BYTES),
        .SP_INIT    (SP_INIT),
        .BP_INIT    (BP_INIT)
    ) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .cmd_data   (cmd_data),
        .frame_size (frame_size),
        .ctl        (ctl),
        .mem_rdata  (mem_rdata),
        .sp         (stack_ptr),
        .bp         (frame_ptr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .misaligned (misaligned)
    );

    stk_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_sel    (ctl.cap_sel),
        .mem_rdata  (mem_rdata),
        .pop_data   (pop_data),
        .ret_target (ret_target)
    );

    assign mem_we = ctl.mem_we;

endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk #(
    parameter int                DATA_W     = 64,
    parameter int                WORD_BYTES = 8,
    parameter logic [DATA_W-1:0] SP_INIT    = DATA_W'(512),
    parameter logic [DATA_W-1:0] BP_INIT    = DATA_W'(512)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] stack_ptr,
    input logic [DATA_W-1:0] frame_ptr
);

    localparam int                ALIGN_BITS = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam logic [DATA_W-1:0] STEP       = DATA_W'(WORD_BYTES);

    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (stack_ptr == SP_INIT && frame_ptr == BP_INIT && !busy && !mem_we)); // R1

    AST_WRITE_BELOW_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == stack_ptr - STEP)); // R2

    AST_WRITE_MOVES_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (stack_ptr == $past(stack_ptr) - STEP)); // R2

    AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ALIGN_BITS-1:0] == '0)); // R8

    AST_FAULT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R7

    AST_IDLE_HOLDS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(stack_ptr) && $stable(frame_ptr))); // R9

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we); // R10

endmodule

bind stack_frame_unit stk_unit_chk #(
    .DATA_W     (DATA_W),
    .WORD_BYTES (WORD_BYTES),
    .SP_INIT    (SP_INIT),
    .BP_INIT    (BP_INIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .stack_ptr (stack_ptr),
    .frame_ptr (frame_ptr)
);

// File: tb/stack_frame_unit_test.sv
`timescale 1ns/1ps
module stack_frame_unit_test;

    localparam logic [63:0] SP0 = 64'h200;
    localparam logic [63:0] BP0 = 64'h200;
    localparam logic [2:0] C_PUSH = 3'd1, C_POP = 3'd2, C_RET = 3'd3,
                           C_ENTER = 3'd4, C_LEAVE = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [63:0] cmd_data;
    logic [15:0] frame_size;
    logic        busy, done, fault, mem_we;
    logic [63:0] pop_data, ret_target, stack_ptr, frame_ptr;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;

    logic [63:0] mem [0:63];
    logic [63:0] ref_mem [0:63];
    logic [63:0] sp_m, bp_m, pop_m, ret_m;
    int          exp_lat, exp_wr;
    logic        exp_flt;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          reported = 0;

    always #4 clk = ~clk;

    stack_frame_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .frame_size(frame_size), .busy(busy), .done(done),
        .fault(fault), .pop_data(pop_data), .ret_target(ret_target),
        .stack_ptr(stack_ptr), .frame_ptr(frame_ptr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    function automatic int idx(input logic [63:0] a);
        return int'(a[8:3]);
    endfunction

    function automatic logic [63:0] fill(input int i);
        return 64'hF00D_5EED_0000_0000 + 64'(i * 3);
    endfunction

    // Bench memory: combinational read, write at the edge, filled during reset
    assign mem_rdata = mem[idx(mem_addr)];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= fill(i);
        end else if (mem_we) begin
            mem[idx(mem_addr)] <= mem_wdata;
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference stack model
    task automatic model(input logic [2:0] op, input logic [63:0] d, input logic [15:0] n);
        exp_flt = 1'b0; exp_wr = 0; exp_lat = 2;
        case (op)
            C_PUSH: if (sp_m[2:0] != 0) exp_flt = 1'b1;
                    else begin sp_m -= 8; ref_mem[idx(sp_m)] = d; exp_wr = 1; end
            C_POP:  if (sp_m[2:0] != 0) exp_flt = 1'b1;
                    else begin pop_m = ref_mem[idx(sp_m)]; sp_m += 8; end
            C_RET:  if (sp_m[2:0] != 0) exp_flt = 1'b1;
                    else begin ret_m = ref_mem[idx(sp_m)]; sp_m += 8; end
            C_ENTER: if (sp_m[2:0] != 0) exp_flt = 1'b1;
                    else begin
                        sp_m -= 8; ref_mem[idx(sp_m)] = bp_m; exp_wr = 1;
                        bp_m = sp_m; sp_m -= 64'(n); exp_lat = 4;
                    end
            C_LEAVE: begin
                sp_m = bp_m;
                if (sp_m[2:0] != 0) begin exp_flt = 1'b1; exp_lat = 3; end
                else begin
                    bp_m = ref_mem[idx(sp_m)]; sp_m += 8;
                    ret_m = ref_mem[idx(sp_m)]; sp_m += 8; exp_lat = 4;
                end
            end
            default: ;
        endcase
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            C_PUSH:  return "R2";
            C_POP:   return "R3";
            C_RET:   return "R4";
            C_ENTER: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(input logic [2:0] op, input logic [63:0] d, input logic [15:0] n);
        int lat = 0;
        int wr = 0;
        int bad = 0;
        logic flt = 1'b0;
        string t = tag_of(op);
        model(op, d, n);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; frame_size = n;
        forever begin
            @(negedge clk);
            cmd_valid = 1'b0;
            lat++;
            if (mem_we) wr++;
            if (done) begin flt = fault; break; end
            if (lat > 16) break;
        end
        chk("R7", "done latency", 64'(lat), 64'(exp_lat));
        chk(exp_flt ? "R8" : t, "fault flag", {63'd0, flt}, {63'd0, exp_flt});
        chk("R10", "write cycles", 64'(wr), 64'(exp_wr));
        chk(t, "stack_ptr", stack_ptr, sp_m);
        chk(t, "frame_ptr", frame_ptr, bp_m);
        chk(exp_flt ? "R8" : "R3", "pop_data", pop_data, pop_m);
        chk(exp_flt ? "R8" : "R4", "ret_target", ret_target, ret_m);
        @(negedge clk);
        for (int i = 0; i < 64; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk(exp_flt ? "R8" : t, "memory words differing", 64'(bad), 64'd0);
        chk("R7", "busy after done", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        void'($urandom(32'd48611));
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0; frame_size = '0;
        sp_m = SP0; bp_m = BP0; pop_m = '0; ret_m = '0;
        for (int i = 0; i < 64; i++) ref_mem[i] = fill(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "stack_ptr", stack_ptr, SP0);
        chk("R1", "frame_ptr", frame_ptr, BP0);
        chk("R1", "busy/done/fault/we", {60'd0, busy, done, fault, mem_we}, 64'd0);
        chk("R1", "pop_data", pop_data, 64'd0);
        chk("R1", "ret_target", ret_target, 64'd0);

        // R2, R3 basic push and pop
        apply(C_PUSH, 64'hA5A5_0001_2345_6789, 16'd0);
        apply(C_PUSH, 64'h0000_0000_0000_0042, 16'd0);
        apply(C_POP, 64'd0, 16'd0);

        // R7 command offered while busy is ignored
        model(C_PUSH, 64'h1111_2222_3333_4444, 16'd0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = C_PUSH; cmd_data = 64'h1111_2222_3333_4444;
        @(negedge clk);
        chk("R7", "busy after take", {63'd0, busy}, 64'd1);
        cmd_data = 64'hDEAD_DEAD_DEAD_DEAD;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R7", "done strobe", {63'd0, done}, 64'd1);
        repeat (3) @(negedge clk);
        chk("R7", "stack_ptr after ignored cmd", stack_ptr, sp_m);
        chk("R7", "stored word", mem[idx(sp_m)], 64'h1111_2222_3333_4444);

        // R9 unused codes
        foreach (C_IGN[k]) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = C_IGN[k]; cmd_data = 64'hBAD;
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R9", "busy on unused code", {63'd0, busy}, 64'd0);
            @(negedge clk);
            chk("R9", "done on unused code", {63'd0, done}, 64'd0);
            chk("R9", "stack_ptr", stack_ptr, sp_m);
            chk("R9", "frame_ptr", frame_ptr, bp_m);
        end

        // R4, R5, R6 nested frames
        apply(C_PUSH, 64'h0000_0000_0040_1000, 16'd0);
        apply(C_ENTER, 64'd0, 16'd16);
        apply(C_PUSH, 64'h7777_0000_0000_0001, 16'd0);
        apply(C_PUSH, 64'h0000_0000_0040_2000, 16'd0);
        apply(C_ENTER, 64'd0, 16'd8);
        apply(C_LEAVE, 64'd0, 16'd0);
        apply(C_POP, 64'd0, 16'd0);
        apply(C_LEAVE, 64'd0, 16'd0);
        apply(C_PUSH, 64'h0000_0000_0040_3000, 16'd0);
        apply(C_RET, 64'd0, 16'd0);

        // R8 misaligned stack pointer after an odd frame size
        apply(C_PUSH, 64'h0000_0000_0040_4000, 16'd0);
        apply(C_ENTER, 64'd0, 16'd4);
        apply(C_PUSH, 64'hCCCC_CCCC_CCCC_CCCC, 16'd0);
        apply(C_POP, 64'd0, 16'd0);
        apply(C_RET, 64'd0, 16'd0);
        apply(C_ENTER, 64'd0, 16'd8);
        apply(C_LEAVE, 64'd0, 16'd0);
        apply(C_LEAVE, 64'd0, 16'd0);

        // Constrained random traffic
        for (int k = 0; k < 400; k++) begin
            logic [2:0]  op = 3'($urandom_range(1, 5));
            logic [63:0] d  = {$urandom, $urandom};
            logic [15:0] n  = 16'(8 * $urandom_range(0, 4));
            bit ok;
            case (op)
                C_PUSH, C_ENTER: ok = (sp_m >= 64'h100);
                C_POP, C_RET:    ok = (sp_m <= 64'h1F8);
                default:         ok = (bp_m >= 64'h80) && (bp_m <= 64'h1F0) && (bp_m[2:0] == 0);
            endcase
            if (!ok) op = (sp_m >= 64'h100) ? C_PUSH : C_POP;
            apply(op, d, n);
        end

        report();
    end

    localparam logic [2:0] C_IGN [3] = '{3'd0, 3'd6, 3'd7};

endmodule